// File: doc/BRIEF.md
# Direct-Mapped Data Cache Access Stage with Deferred Store

This block is the memory-access stage of a five-stage integer pipeline's data cache. The cache is direct mapped and tagged with the virtual address. Each line holds one 32-bit word, has its own valid bit, and is kept in two separate arrays, one for tags and one for data. A load reads both arrays in its access cycle. It reports a hit or a miss in that same cycle and returns the word on a hit. A miss tells the pipeline to suspend while an external refill engine fetches the line.

A store only consults the tag array in its access cycle, because the data array cannot be written until the store is known to be a hit. On a hit, the store's word address and data are parked in a one-entry deferred-store register. That entry is written into the data array during the access of the next store that hits. A load whose word address equals the parked address takes the parked data in place of the array word, with unchanged timing. A late exception on the parked store drops the entry so that it never reaches the data array. A fill port installs a line (tag, data and valid bit) on behalf of the refill engine.

Top module: `dc_access_stage`

## Requirements
- R1: While reset is held and on the first cycle after it, every line is invalid and the deferred-store entry is empty. Any load or store issued before the first fill therefore reports a miss.
- R2: A load hits when its line is valid and the stored tag equals address bits [31:2+IDX_W]. The index is address bits [2+IDX_W-1:2], and bits [1:0] are ignored. The hit flag and the word are presented combinationally in the same cycle as the access.
- R3: A load whose index matches a valid line but whose tag differs raises the miss output and leaves the hit output low.
- R4: A fill writes the tag, data and valid bit of the line chosen by the fill address at the clock edge. A load of the same word on any later cycle hits and returns the filled data.
- R5: A store that hits does not change the data array in its own access cycle.
- R6: A store that hits captures its word address and data as the deferred-store entry at the clock edge. If an entry was already valid and was not cancelled, that older entry is written into the data array at the same edge.
- R7: A load whose word address (bits [31:2]) equals a valid deferred-store entry returns the entry's data instead of the array word.
- R8: When the cancel input is high, the deferred-store entry becomes invalid at the clock edge. A cancelled entry is never written into the data array.
- R9: A store that misses raises the miss output. It neither captures nor drains the deferred-store entry.
- R10: A deferred entry is written into the data array only if its line is still valid with the entry's tag at drain time. If a fill has since replaced that line with a different tag, the drain is skipped and the line keeps its fill data.
- R11: When a hitting store and the cancel input occur in the same cycle, the older entry is dropped without being written. The new store becomes the valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is in the stage this cycle |
| acc_store | input | 1 | 1 = store access, 0 = load access |
| acc_addr | input | 32 | Virtual byte address of the access |
| acc_wdata | input | 32 | Store data |
| exc_cancel | input | 1 | The parked store took an exception; drop its entry |
| fill_en | input | 1 | Install a line from the refill engine |
| fill_addr | input | 32 | Address of the line being installed |
| fill_data | input | 32 | Word written into the installed line |
| hit | output | 1 | The access found its line resident |
| miss | output | 1 | The access did not find its line; suspend the pipeline |
| ld_data | output | 32 | Load result (array word or forwarded deferred data) |

## Verification
The bench builds the block with IDX_W = 3, which gives eight lines. Addresses 0x100 and 0x200 then share index 0 with different tags, so eviction, tag mismatch and the guarded drain after an eviction can all be reached with a handful of addresses. The unused byte-offset bits are also varied, so that forwarding is seen to depend on the word address only.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OFS_W   = 2;
    localparam int unsigned WADDR_W = ADDR_W - OFS_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

    // One parked store: word address, data and a valid flag.
    typedef struct packed {
        logic   valid;
        waddr_t waddr;
        word_t  data;
    } sq_entry_t;

    function automatic waddr_t word_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array
    import dc_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = WADDR_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [LINES-1:0] line_v;
    logic [TAG_W-1:0] line_t [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             sel;

        assign sel = we && (w_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= w_tag;
            end
        end

        assign line_v[g] = v_q;
        assign line_t[g] = t_q;
    end

    // Port A serves the access, port B checks the parked store's line.
    assign ra_valid = line_v[ra_idx];
    assign ra_tag   = line_t[ra_idx];
    assign rb_valid = line_v[rb_idx];
    assign rb_tag   = line_t[rb_idx];
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array
    import dc_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  word_t            fill_word,
    input  logic             drain_we,
    input  logic [IDX_W-1:0] drain_idx,
    input  word_t            drain_word
);
    localparam int unsigned LINES = 1 << IDX_W;

    word_t line_d [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        word_t d_q;
        logic  fill_sel;
        logic  drain_sel;

        assign fill_sel  = fill_we  && (fill_idx  == IDX_W'(g));
        assign drain_sel = drain_we && (drain_idx == IDX_W'(g));

        // A refill of the same line takes precedence over a drain.
        always_ff @(posedge clk) begin
            if (fill_sel) begin
                d_q <= fill_word;
            end else if (drain_sel) begin
                d_q <= drain_word;
            end
        end

        assign line_d[g] = d_q;
    end

    assign rd_word = line_d[rd_idx];
endmodule

// File: rtl/dc_store_queue.sv
module dc_store_queue
    import dc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  waddr_t    cap_waddr,
    input  word_t     cap_data,
    input  logic      cancel,
    input  waddr_t    probe_waddr,
    output sq_entry_t entry,
    output logic      drain_req,
    output logic      probe_match
);
    sq_entry_t entry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '0;
        end else if (capture) begin
            entry_q.valid <= 1'b1;
            entry_q.waddr <= cap_waddr;
            entry_q.data  <= cap_data;
        end else if (cancel) begin
            entry_q.valid <= 1'b0;
        end
    end

    assign entry       = entry_q;
    assign drain_req   = capture && entry_q.valid && !cancel;
    assign probe_match = entry_q.valid && (entry_q.waddr == probe_waddr);
endmodule

// File: rtl/dc_access_stage.sv
module dc_access_stage
    import dc_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_store,
    input  logic [31:0] acc_addr,
    input  logic [31:0] acc_wdata,
    input  logic        exc_cancel,
    input  logic        fill_en,
    input  logic [31:0] fill_addr,
    input  logic [31:0] fill_data,
    output logic        hit,
    output logic        miss,
    output logic [31:0] ld_data
);
    localparam int unsigned TAG_W = WADDR_W - IDX_W;

    op_e              acc_op;
    waddr_t           acc_w;
    waddr_t           fill_w;
    logic [IDX_W-1:0] acc_idx;
    logic [TAG_W-1:0] acc_tag;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;

    assign acc_op   = op_e'(acc_store);
    assign acc_w    = word_of(acc_addr);
    assign fill_w   = word_of(fill_addr);
    assign acc_idx  = acc_w[IDX_W-1:0];
    assign acc_tag  = acc_w[WADDR_W-1 -: TAG_W];
    assign fill_idx = fill_w[IDX_W-1:0];
    assign fill_tag = fill_w[WADDR_W-1 -: TAG_W];

    sq_entry_t        sq_q;
    logic             sq_valid;
    waddr_t           sq_waddr;
    word_t            sq_data;
    logic [IDX_W-1:0] sq_idx;
    logic [TAG_W-1:0] sq_tag;

    assign sq_valid = sq_q.valid;
    assign sq_waddr = sq_q.waddr;
    assign sq_data  = sq_q.data;
    assign sq_idx   = sq_q.waddr[IDX_W-1:0];
    assign sq_tag   = sq_q.waddr[WADDR_W-1 -: TAG_W];

    logic             tag_valid;
    logic [TAG_W-1:0] tag_word;
    logic             dr_valid;
    logic [TAG_W-1:0] dr_tag;

    dc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .ra_idx   (acc_idx),
        .ra_valid (tag_valid),
        .ra_tag   (tag_word),
        .rb_idx   (sq_idx),
        .rb_valid (dr_valid),
        .rb_tag   (dr_tag),
        .we       (fill_en),
        .w_idx    (fill_idx),
        .w_tag    (fill_tag)
    );

    logic lookup_hit;
    logic store_hit;
    logic drain_req;
    logic drain_ok;
    logic fwd_match;

    assign lookup_hit = acc_valid && tag_valid && (tag_word == acc_tag);
    assign store_hit  = lookup_hit && (acc_op == OP_STORE);

    dc_store_queue u_sq (
        .clk         (clk),
        .rst         (rst),
        .capture     (store_hit),
        .cap_waddr   (acc_w),
        .cap_data    (acc_wdata),
        .cancel      (exc_cancel),
        .probe_waddr (acc_w),
        .entry       (sq_q),
        .drain_req   (drain_req),
        .probe_match (fwd_match)
    );

    // Drain only into a line that still holds the parked store's tag.
    assign drain_ok = drain_req && dr_valid && (dr_tag == sq_tag);

    word_t arr_word;

    dc_data_array #(.IDX_W(IDX_W)) u_data (
        .clk        (clk),
        .rd_idx     (acc_idx),
        .rd_word    (arr_word),
        .fill_we    (fill_en),
        .fill_idx   (fill_idx),
        .fill_word  (fill_data),
        .drain_we   (drain_ok),
        .drain_idx  (sq_idx),
        .drain_word (sq_data)
    );

    assign hit     = lookup_hit;
    assign miss    = acc_valid && !lookup_hit;
    assign ld_data = (acc_op == OP_LOAD && fwd_match) ? sq_data : arr_word;
endmodule

// File: rtl/dc_access_checker.sv
module dc_access_checker
    import dc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_store,
    input logic [31:0] acc_addr,
    input logic [31:0] acc_wdata,
    input logic        exc_cancel,
    input logic        fill_en,
    input logic [31:0] fill_addr,
    input logic        hit,
    input logic        miss,
    input logic [31:0] ld_data,
    input logic        q_valid,
    input waddr_t      q_waddr,
    input word_t       q_data
);
    // R1: the parked entry is empty after reset.
    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> !q_valid);

    // R6: a hitting store becomes the parked entry.
    a_r6_store_hit_parks: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_store && hit)
        |=> (q_valid && q_waddr == $past(acc_addr[ADDR_W-1:OFS_W])
             && q_data == $past(acc_wdata)));

    // R9: a missing store leaves the parked entry alone.
    a_r9_store_miss_holds: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_store && miss && !exc_cancel)
        |=> ($stable(q_valid) && $stable(q_waddr) && $stable(q_data)));

    // R8: cancel without a new hitting store empties the entry.
    a_r8_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        (exc_cancel && !(acc_valid && acc_store && hit)) |=> !q_valid);

    // R7: a load of the parked word returns the parked data.
    a_r7_forward_data: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_store && q_valid
         && q_waddr == acc_addr[ADDR_W-1:OFS_W]) |-> (ld_data == q_data));

    // R4: an access of the word filled on the previous cycle hits.
    a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && $past(fill_en)
         && acc_addr[ADDR_W-1:OFS_W] == $past(fill_addr[ADDR_W-1:OFS_W]))
        |-> hit);
endmodule

bind dc_access_stage dc_access_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_store  (acc_store),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .exc_cancel (exc_cancel),
    .fill_en    (fill_en),
    .fill_addr  (fill_addr),
    .hit        (hit),
    .miss       (miss),
    .ld_data    (ld_data),
    .q_valid    (sq_valid),
    .q_waddr    (sq_waddr),
    .q_data     (sq_data)
);

// File: tb/tb_dc_access_stage.sv
module tb_dc_access_stage;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 3;
    localparam int LINES      = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_store = 1'b0, exc_cancel = 1'b0, fill_en = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0, fill_addr = '0, fill_data = '0;
    logic        hit, miss;
    logic [31:0] ld_data;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // Reference state
    bit          mv [LINES];
    logic [31:0] mt [LINES];
    logic [31:0] md [LINES];
    bit          qv = 1'b0;
    logic [31:0] qa = '0;
    logic [31:0] qd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_access_stage #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .exc_cancel(exc_cancel),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .hit(hit), .miss(miss), .ld_data(ld_data)
    );

    function automatic int idx_of(logic [31:0] a);
        return int'((a >> 2) & 32'(LINES - 1));
    endfunction

    function automatic logic [31:0] tag_of(logic [31:0] a);
        return a >> (2 + IDX_W);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(string req, bit v, bit st, logic [31:0] a, logic [31:0] wd,
                        bit cx, bit fe, logic [31:0] fa, logic [31:0] fd);
        int          i;
        int          qi;
        int          fi;
        bit          e_hit;
        logic [31:0] e_data;
        @(negedge clk);
        acc_valid = v; acc_store = st; acc_addr = a; acc_wdata = wd;
        exc_cancel = cx; fill_en = fe; fill_addr = fa; fill_data = fd;
        #1;
        i      = idx_of(a);
        e_hit  = v && mv[i] && (mt[i] == tag_of(a));
        e_data = (!st && qv && qa == (a >> 2)) ? qd : md[i];
        check(req, {30'd0, hit, miss}, {30'd0, e_hit, v && !e_hit}, "hit/miss");
        if (v && !st && e_hit) check(req, ld_data, e_data, "load data");
        @(posedge clk);
        #1;
        if (v && st && e_hit && qv && !cx) begin
            qi = int'(qa & 32'(LINES - 1));
            if (mv[qi] && mt[qi] == (qa >> IDX_W)) md[qi] = qd;
        end
        if (fe) begin
            fi = idx_of(fa);
            mv[fi] = 1'b1; mt[fi] = tag_of(fa); md[fi] = fd;
        end
        if (v && st && e_hit) begin
            qv = 1'b1; qa = a >> 2; qd = wd;
        end else if (cx) begin
            qv = 1'b0;
        end
    endtask

    task automatic ld(string req, logic [31:0] a);
        step(req, 1'b1, 1'b0, a, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic stw(string req, logic [31:0] a, logic [31:0] d, bit cx);
        step(req, 1'b1, 1'b1, a, d, cx, 1'b0, '0, '0);
    endtask

    task automatic fill(string req, logic [31:0] a, logic [31:0] d);
        step(req, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        for (int k = 0; k < LINES; k++) begin
            mv[k] = 1'b0; mt[k] = '0; md[k] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1", {30'd0, hit, miss}, 32'd0, "idle outputs in reset");
        @(negedge clk);
        rst = 1'b0;
        // R1: nothing resident after reset
        ld("R1", 32'h0000_0100);
        stw("R1", 32'h0000_0104, 32'hDEAD_0001, 1'b0);
        // R4: fills then hits
        fill("R4", 32'h0000_0100, 32'h0000_0011);
        fill("R4", 32'h0000_0104, 32'h0000_0022);
        ld("R4", 32'h0000_0100);
        ld("R2", 32'h0000_0107);
        // R3: same index, other tag
        ld("R3", 32'h0000_0200);
        // R9: store miss neither parks nor drains
        stw("R9", 32'h0000_0200, 32'hBAD0_0009, 1'b0);
        ld("R9", 32'h0000_0100);
        // R6/R7: park then forward, offset bits ignored
        stw("R6", 32'h0000_0100, 32'h0000_00AA, 1'b0);
        ld("R7", 32'h0000_0100);
        ld("R7", 32'h0000_0102);
        // R6: next hitting store drains the older entry
        stw("R6", 32'h0000_0104, 32'h0000_00BB, 1'b0);
        ld("R6", 32'h0000_0100);
        ld("R7", 32'h0000_0104);
        // R8/R5: cancelled entry never lands; store cycle did not write
        step("R8", 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, '0, '0);
        ld("R5", 32'h0000_0104);
        stw("R8", 32'h0000_0100, 32'h0000_00CC, 1'b0);
        ld("R8", 32'h0000_0104);
        // R10: line evicted before drain, drain skipped
        fill("R10", 32'h0000_0200, 32'h0000_0033);
        stw("R10", 32'h0000_0104, 32'h0000_00DD, 1'b0);
        ld("R10", 32'h0000_0200);
        fill("R10", 32'h0000_0100, 32'h0000_0044);
        ld("R10", 32'h0000_0100);
        // R11: hitting store with cancel in the same cycle
        stw("R11", 32'h0000_0100, 32'h0000_0055, 1'b1);
        ld("R11", 32'h0000_0104);
        ld("R11", 32'h0000_0100);
        stw("R11", 32'h0000_0104, 32'h0000_0066, 1'b0);
        ld("R11", 32'h0000_0100);
        ld("R11", 32'h0000_0104);
        // R2: loads of untouched lines after all of the above
        fill("R2", 32'h0000_011C, 32'h0000_0077);
        step("R2", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
        ld("R2", 32'h0000_011C);
        ld("R3", 32'h0000_021C);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule